// File: doc/BRIEF.md
# Independent-Channel Voltage-Triggered Rail Sequencer

The block controls the gate drivers of four power rails. On the way up each rail is fully independent. A channel's gate-enable output turns on as soon as the global enable is high and that channel's own undervoltage comparator reports the rail input as good. No channel waits for any other. The comparator inputs can come from rails that are already up, which gives a sequence set by voltage, or from plain logic signals.

The active-low system reset output is released only after all four gates have reported fully on, without a break, for a hold time. If one channel's undervoltage input fails while the block is enabled, only that gate drops and the system reset is pulled low again. The other gates stay on.

Dropping the enable starts an orderly shutdown and also forces the system reset low. The gates are switched off from the highest channel down to channel 0. Each lower gate is switched off only after the gate above it reports that it is below its low threshold, followed by a programmable step delay. The hold time and the step delay are parameters counted in clock cycles.

Top module: `rail_seq_indep`

## Requirements
- R1: While rst_ni is low, every bit of gate_en_o is 0 and sys_rst_no is 0.
- R2: Bit n of gate_en_o is 1 after any rising clock edge at which en_i and uv_ok_i[n] are both 1. This holds whatever the other channels' inputs and outputs are.
- R3: While en_i is 1, a rising clock edge at which uv_ok_i[n] is 0 clears gate_en_o[n]. That edge leaves every other channel's gate bit at its value from its own inputs.
- R4: sys_rst_no goes to 1 at the HOLD_CYCLES-th consecutive rising edge at which all of the following are 1: en_i, all four uv_ok_i bits, all four gate_en_o bits and all four gate_on_i bits. It goes to 0 at the first edge at which any of them is 0.
- R5: A rising edge at which en_i is 0 leaves gate_en_o[3] at 0 and sys_rst_no at 0. When en_i falls with the block running, that edge starts the shutdown by clearing gate_en_o[3].
- R6: During shutdown, gate_en_o[k-1] is cleared at edge e0+STEP_CYCLES, for k from 3 down to 1. Here e0 is the first edge, after gate k was cleared, at which gate_low_i[k] is sampled as 1. The gates are cleared in the order 3, 2, 1, 0.
- R7: With STEP_CYCLES = 0, gate_en_o[k-1] is cleared at the very edge at which gate_low_i[k] is first sampled as 1, so it reads 0 one cycle after the flag is seen.
- R8: While en_i is 0, no gate_en_o bit goes from 0 to 1. A gate that the shutdown has not yet reached still clears at the next edge if its uv_ok_i bit is 0.
- R9: Raising en_i during or after shutdown makes every gate follow its uv_ok_i bit from the next edge. sys_rst_no stays 0 until a new, uninterrupted hold of HOLD_CYCLES edges (as in R4) is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable, active high |
| uv_ok_i | input | NUM_CH | Per-channel undervoltage comparator, 1 = rail input good |
| gate_on_i | input | NUM_CH | Per-channel status, 1 = gate fully on |
| gate_low_i | input | NUM_CH | Per-channel status, 1 = gate below its low threshold |
| gate_en_o | output | NUM_CH | Per-channel gate-drive enable |
| sys_rst_no | output | 1 | System reset, active low, released high when all rails are up |

## Verification
Assertions check four things on every cycle:
- each gate follows its own enable and undervoltage condition, on the way up and on a single-channel fault;
- no gate turns back on while the block is disabled;
- the system reset is held low on any cycle after a failed condition or a dropped enable;
- the shutdown pointer never advances before the low flag of the gate it waits on.

Only the bench scenarios can show the exact timing of each shutdown step against its delay, and the full hold count before the reset is released. They also show that a reset latched low by a disable needs a complete new hold, and that re-enabling in the middle of a shutdown aborts it. The bench runs a second unit with zero step delay on the same stimulus to cover the back-to-back step case.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;
  typedef enum logic [1:0] {
    SD_IDLE,
    SD_RUN,
    SD_WAIT,
    SD_DELAY
  } sd_state_e;
endpackage

// File: rtl/rail_seq_gate_bank.sv
module rail_seq_gate_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_CH-1:0] uv_ok_i,
  input  logic [NUM_CH-1:0] kill_i,
  output logic [NUM_CH-1:0] gate_o
);
  logic [NUM_CH-1:0] gate_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   gate_q[n] <= 1'b0;
      else if (en_i) gate_q[n] <= uv_ok_i[n];
      else           gate_q[n] <= gate_q[n] & uv_ok_i[n] & ~kill_i[n];
    end

    // R2
    ch_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i && uv_ok_i[n] |=> gate_q[n]);
    // R3
    ch_uv_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !uv_ok_i[n] |=> !gate_q[n]);
    // R8
    ch_no_rise_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i && !gate_q[n] |=> !gate_q[n]);
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/rail_seq_shutdown.sv
module rail_seq_shutdown
  import rail_seq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int STEP_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_CH-1:0] gate_low_i,
  output logic [NUM_CH-1:0] kill_o
);
  localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CNT_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [PTR_W-1:0] TOP_CH = PTR_W'(NUM_CH - 1);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(STEP_CYCLES - 1);

  sd_state_e         st_q, st_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              adv;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    cnt_d  = cnt_q;
    adv    = 1'b0;
    kill_o = '0;
    unique case (st_q)
      SD_IDLE: if (en_i) st_d = SD_RUN;
      SD_RUN: begin
        if (!en_i) begin
          kill_o[NUM_CH-1] = 1'b1;
          ptr_d = TOP_CH;
          st_d  = SD_WAIT;
        end
      end
      SD_WAIT: begin
        if (en_i) st_d = SD_RUN;
        else if (gate_low_i[ptr_q]) begin
          if (STEP_CYCLES == 0) adv = 1'b1;
          else begin
            st_d  = SD_DELAY;
            cnt_d = '0;
          end
        end
      end
      SD_DELAY: begin
        if (en_i) st_d = SD_RUN;
        else if (cnt_q == CNT_LIM) adv = 1'b1;
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = SD_IDLE;
    endcase
    if (adv) begin
      kill_o[ptr_q - PTR_W'(1)] = 1'b1;
      ptr_d = ptr_q - PTR_W'(1);
      st_d  = (ptr_q == PTR_W'(1)) ? SD_IDLE : SD_WAIT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SD_IDLE;
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  // R6
  one_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(kill_o));
  // R6
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == SD_WAIT && !en_i && !gate_low_i[ptr_q] |=> $stable(ptr_q));
endmodule

// File: rtl/rail_seq_ready.sv
module rail_seq_ready #(
  parameter int NUM_CH      = 4,
  parameter int HOLD_CYCLES = 37_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_CH-1:0] uv_ok_i,
  input  logic [NUM_CH-1:0] gate_en_i,
  input  logic [NUM_CH-1:0] gate_on_i,
  output logic              rel_o
);
  localparam int HOLD_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HOLD_W-1:0] HOLD_LIM = HOLD_W'(HOLD_CYCLES - 1);

  logic              all_up;
  logic [HOLD_W-1:0] hold_q;
  logic              rel_q;

  assign all_up = en_i & (&uv_ok_i) & (&gate_en_i) & (&gate_on_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rel_q  <= 1'b0;
    end else if (!all_up) begin
      hold_q <= '0;
      rel_q  <= 1'b0;
    end else if (hold_q == HOLD_LIM) begin
      rel_q  <= 1'b1;
    end else begin
      hold_q <= hold_q + 1'b1;
    end
  end

  // R4
  rel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_up |=> !rel_q);
  // R4
  rel_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> $past(all_up));

  assign rel_o = rel_q;
endmodule

// File: rtl/rail_seq_indep.sv
module rail_seq_indep #(
  parameter int NUM_CH      = 4,
  parameter int HOLD_CYCLES = 37_500_000,
  parameter int STEP_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NUM_CH-1:0] uv_ok_i,
  input  logic [NUM_CH-1:0] gate_on_i,
  input  logic [NUM_CH-1:0] gate_low_i,
  output logic [NUM_CH-1:0] gate_en_o,
  output logic              sys_rst_no
);
  logic [NUM_CH-1:0] kill;
  logic              rel;

  rail_seq_shutdown #(.NUM_CH(NUM_CH), .STEP_CYCLES(STEP_CYCLES)) u_sd (
    .clk_i, .rst_ni, .en_i, .gate_low_i, .kill_o(kill)
  );

  rail_seq_gate_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk_i, .rst_ni, .en_i, .uv_ok_i, .kill_i(kill), .gate_o(gate_en_o)
  );

  rail_seq_ready #(.NUM_CH(NUM_CH), .HOLD_CYCLES(HOLD_CYCLES)) u_rdy (
    .clk_i, .rst_ni, .en_i, .uv_ok_i, .gate_en_i(gate_en_o), .gate_on_i,
    .rel_o(rel)
  );

  assign sys_rst_no = rel;

  // R5
  dis_top_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_en_o[NUM_CH-1] && !sys_rst_no);
endmodule

// File: tb/rail_seq_indep_bench.sv
module rail_seq_indep_bench;
  localparam int HOLD = 8;
  localparam int STEP = 3;

  typedef struct {
    logic [3:0] gate;
    logic       rel;
    int         hold;
    int         mode;
    int         cur;
    int         tmr;
  } mdl_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en = 1'b0;
  logic [3:0] uv = 4'h0;
  logic [3:0] on_mask = 4'h0;
  logic [3:0] on_a = 4'h0, low_a = 4'hF, on_z = 4'h0, low_z = 4'hF;
  logic [3:0] gate_a, gate_z;
  logic       rel_a, rel_z;
  int         lag [4] = '{1, 4, 0, 2};
  int         offc_a [4] = '{0, 0, 0, 0};
  int         offc_z [4] = '{0, 0, 0, 0};
  int         n_vec = 0, n_bad = 0, cyc = 0;
  string      tag = "R1";
  mdl_t       ma, mz;

  always #2 clk = ~clk;

  rail_seq_indep #(.NUM_CH(4), .HOLD_CYCLES(HOLD), .STEP_CYCLES(STEP)) u_rail_seq_indep (
    .clk_i(clk), .rst_ni, .en_i(en), .uv_ok_i(uv), .gate_on_i(on_a),
    .gate_low_i(low_a), .gate_en_o(gate_a), .sys_rst_no(rel_a)
  );

  rail_seq_indep #(.NUM_CH(4), .HOLD_CYCLES(HOLD), .STEP_CYCLES(0)) u_rail_seq_indep_z (
    .clk_i(clk), .rst_ni, .en_i(en), .uv_ok_i(uv), .gate_on_i(on_z),
    .gate_low_i(low_z), .gate_en_o(gate_z), .sys_rst_no(rel_z)
  );

  function automatic mdl_t mstep(mdl_t s, int step, logic e, logic [3:0] u,
                                 logic [3:0] on, logic [3:0] low);
    mdl_t r = s;
    int t;
    if (e && u == 4'hF && s.gate == 4'hF && on == 4'hF) begin
      r.hold = s.hold + 1;
      r.rel  = (r.hold >= HOLD);
    end else begin
      r.hold = 0;
      r.rel  = 1'b0;
    end
    if (e) begin
      r.gate = u; r.mode = 1; r.tmr = -1;
    end else begin
      r.gate = s.gate & u;
      if (s.mode == 1) begin
        r.gate[3] = 1'b0; r.cur = 3; r.mode = 2; r.tmr = -1;
      end else if (s.mode == 2) begin
        t = s.tmr;
        if (t < 0 && low[s.cur]) t = 0;
        if (t >= 0) begin
          if (t == step) begin
            r.gate[s.cur-1] = 1'b0;
            r.cur = s.cur - 1;
            t = -1;
            if (r.cur == 0) r.mode = 0;
          end else t = t + 1;
        end
        r.tmr = t;
      end
    end
    return r;
  endfunction

  function automatic mdl_t mreset();
    mdl_t r;
    r.gate = 4'h0; r.rel = 1'b0; r.hold = 0; r.mode = 0; r.cur = 0; r.tmr = -1;
    return r;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_ni) begin
      ma = mreset();
      mz = mreset();
    end else begin
      ma = mstep(ma, STEP, en, uv, on_a, low_a);
      mz = mstep(mz, 0, en, uv, on_z, low_z);
    end
  end

  task automatic check(string t, logic [4:0] act, logic [4:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual={rst_n,gates}=%b expected=%b", t, act, exp);
    end
  endtask

  task automatic plant();
    for (int n = 0; n < 4; n++) begin
      offc_a[n] = gate_a[n] ? 0 : offc_a[n] + 1;
      offc_z[n] = gate_z[n] ? 0 : offc_z[n] + 1;
      low_a[n]  = (offc_a[n] > lag[n]);
      low_z[n]  = (offc_z[n] > lag[n]);
    end
    on_a = gate_a & ~on_mask;
    on_z = gate_z & ~on_mask;
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      check(tag, {rel_a, gate_a}, {ma.rel, ma.gate});
      check({tag, " R7"}, {rel_z, gate_z}, {mz.rel, mz.gate});
      plant();
    end
  endtask

  initial begin
    run(3);
    // R1 fixed reset values
    check("R1", {rel_a, gate_a}, 5'b0_0000);
    check("R1", {rel_z, gate_z}, 5'b0_0000);
    rst_ni = 1'b1;
    tag = "R2"; en = 1'b1; uv = 4'b0100; run(3);
    check("R2", {1'b0, gate_a}, 5'b0_0100);
    uv = 4'b0101; run(2);
    uv = 4'b1111; run(4);
    tag = "R4"; run(HOLD + 2);
    check("R4", {rel_a, gate_a}, 5'b1_1111);
    on_mask = 4'b0100; run(2);
    check("R4", {rel_a, 4'h0}, 5'b0_0000);
    on_mask = 4'b0000; run(HOLD + 3);
    tag = "R3"; uv = 4'b1101; run(3);
    check("R3", {rel_a, gate_a}, 5'b0_1101);
    uv = 4'b1111; run(HOLD + 4);
    tag = "R5"; en = 1'b0; run(1);
    check("R5", {rel_a, gate_a}, 5'b0_0111);
    tag = "R6"; run(6);
    tag = "R8"; uv = 4'b1110; run(3);
    uv = 4'b1111; tag = "R6"; run(25);
    check("R6", {rel_a, gate_a}, 5'b0_0000);
    tag = "R9"; en = 1'b1; run(3);
    check("R9", {rel_a, gate_a}, 5'b0_1111);
    run(HOLD + 4);
    tag = "R5"; en = 1'b0; run(8);
    tag = "R9"; en = 1'b1; run(HOLD + 6);
    tag = "R6"; en = 1'b0; run(40);
    tag = "R1"; rst_ni = 1'b0; run(2);
    check("R1", {rel_a, gate_a}, 5'b0_0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=5000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule